// File: doc/BRIEF.md
# Buffered 8/16-bit Timer-Counter

This peripheral counts either instruction cycles or edges on an external input pin. It can run as an 8-bit or a 16-bit counter. The instruction cycle is the system clock divided by a fixed ratio (four by default). An optional power-of-two prescaler sits in front of the counter and divides its input. A sticky overflow flag is raised whenever the counter wraps. Software reaches the block through a four-entry byte-wide register interface made of a control register, the counter low byte, a high-byte buffer and the flag register.

In 16-bit mode the upper byte of the counter is hidden from the bus. A read of the low byte copies the live upper byte into the buffer, so the two bytes always form one snapshot. A write of the low byte loads the upper byte from the buffer in the same clock, so all sixteen bits change together. Any write to the low byte also holds the counter still for the next two instruction cycles and clears the prescaler. The external pin is resampled on instruction-cycle boundaries through a two-stage synchronizer, followed by an edge detector.

Top module: `btc_timer`

## Requirements
- R1: After reset, the control register (address 0) reads 0xE7, the low byte (address 1) reads 0x00 and the flag register (address 3) reads 0x00. Control fields: bit 7 run, bit 6 eight-bit mode, bit 5 external source, bit 4 falling edge, bit 3 prescaler bypass, bits 2:0 ratio code.
- R2: With the internal source selected, the prescaler bypassed and run set, the counter advances by exactly one every instruction cycle (four system clocks).
- R3: A write to the low byte suppresses the counts of the next two instruction cycles. The third instruction cycle after the write counts normally.
- R4: With the prescaler in use, ratio code k advances the counter once every 2^(k+1) input events. A low-byte write resets the prescaler, so after such a write the (2^(k+1))-th counted event is the first to advance the counter.
- R5: With the external source selected and the falling-edge bit clear, each rising edge of the pin adds one. The count appears on the third instruction-cycle boundary after the pin changes.
- R6: With the falling-edge bit set, rising edges are ignored and each falling edge adds one.
- R7: While the run bit is clear, the count does not change.
- R8: In 16-bit mode, reading the low byte copies the live high byte into the buffer (address 2). The buffer keeps that value until the next low-byte read or buffer write, even if the counter carries into its high byte.
- R9: In 16-bit mode, a buffer write leaves the live high byte unchanged. A low-byte write loads the live high byte from the buffer and the low byte from the written data in the same clock.
- R10: Bit 0 of the flag register is set when the counter wraps from 0xFF in 8-bit mode or from 0xFFFF in 16-bit mode. Writing 1 to it has no effect. Writing 0 clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | 2 | Register select: 0 control, 1 low byte, 2 high buffer, 3 flag |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (triggers the high-byte snapshot) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register |
| tmr_pin_i | input | 1 | External count input, asynchronous |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with its default parameters: a divide-by-four instruction cycle, a two-stage pin synchronizer and a two-cycle write hold. Because each window of four clocks holds exactly one instruction cycle, the bench can predict exact counts over windows that are multiples of four clocks, whatever the phase of the divider. These settings also let it place checks on the exact clock where the write hold ends and where the synchronizer delay runs out. The small 8-bit width puts both wrap points within a few instruction cycles of a preset value.

// File: rtl/btc_pkg.sv
package btc_pkg;

    localparam int unsigned DW = 8;   // register and counter half width
    localparam int unsigned SW = 3;   // prescaler ratio code width
    localparam int unsigned PW = 8;   // prescaler counter width (2**SW)

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_LOW  = 2'd1,
        REG_HBUF = 2'd2,
        REG_FLAG = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic          run;
        logic          narrow;
        logic          ext_src;
        logic          fall_edge;
        logic          no_pre;
        logic [SW-1:0] ratio;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{run: 1'b1, narrow: 1'b1, ext_src: 1'b1,
                                   fall_edge: 1'b0, no_pre: 1'b0, ratio: 3'd7};

endpackage

// File: rtl/btc_tick_gen.sv
module btc_tick_gen #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned PHW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PHW-1:0] LAST = PHW'(DIV - 1);

    logic [PHW-1:0] ph_d, ph_q;

    always_comb begin
        tick_o = (ph_q == LAST);
        ph_d   = tick_o ? '0 : ph_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end
endmodule

// File: rtl/btc_edge_sync.sv
module btc_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic pin_i,
    input  logic fall_i,
    output logic pulse_o
);
    logic [STAGES-1:0] sh_d, sh_q;
    logic              prev_d, prev_q;
    logic              newest;

    always_comb begin
        sh_d   = sh_q;
        prev_d = prev_q;
        newest = sh_q[STAGES-1];
        if (tick_i) begin
            sh_d   = STAGES'({sh_q, pin_i});
            prev_d = newest;
        end
        pulse_o = tick_i && (fall_i ? (prev_q && !newest) : (!prev_q && newest));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            prev_q <= 1'b0;
        end else begin
            sh_q   <= sh_d;
            prev_q <= prev_d;
        end
    end
endmodule

// File: rtl/btc_prescale.sv
module btc_prescale #(
    parameter int unsigned PW = 8,
    parameter int unsigned SW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          pulse_i,
    input  logic          bypass_i,
    input  logic [SW-1:0] sel_i,
    output logic          adv_o
);
    logic [PW-1:0] cnt_d, cnt_q;
    logic [PW-1:0] mask;

    always_comb begin
        for (int i = 0; i < PW; i++) mask[i] = (i <= int'(sel_i));
        adv_o = pulse_i && (bypass_i || ((cnt_q & mask) == mask));
        cnt_d = cnt_q;
        if (pulse_i) cnt_d = cnt_q + 1'b1;
        if (clr_i)   cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/btc_timer.sv
module btc_timer
    import btc_pkg::*;
#(
    parameter int unsigned CYC_DIV     = 4,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned HOLD_CYC    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    addr_i,
    input  logic          wr_en_i,
    input  logic          rd_en_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    input  logic          tmr_pin_i,
    output logic          ovf_o
);
    localparam int unsigned HW = $clog2(HOLD_CYC + 1);

    typedef struct packed {
        ctrl_t         ctrl;
        logic [DW-1:0] lo;
        logic [DW-1:0] hi;
        logic [DW-1:0] hbuf;
        logic          ovf;
        logic [HW-1:0] hold;
    } state_t;

    state_t s_d, s_q;

    logic tick, ext_pulse, src_pulse, live, adv, wrap;
    logic wr_ctrl, wr_low, wr_hbuf, wr_flag, rd_low;

    // exposed for the bound checker
    logic [DW-1:0] lo_w, hi_w, hbuf_w;
    logic          run_w, narrow_w;

    btc_tick_gen #(.DIV(CYC_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    btc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .pin_i   (tmr_pin_i),
        .fall_i  (s_q.ctrl.fall_edge),
        .pulse_o (ext_pulse)
    );

    btc_prescale #(.PW(PW), .SW(SW)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (wr_low),
        .pulse_i  (live),
        .bypass_i (s_q.ctrl.no_pre),
        .sel_i    (s_q.ctrl.ratio),
        .adv_o    (adv)
    );

    always_comb begin
        wr_ctrl   = wr_en_i && (addr_i == REG_CTRL);
        wr_low    = wr_en_i && (addr_i == REG_LOW);
        wr_hbuf   = wr_en_i && (addr_i == REG_HBUF);
        wr_flag   = wr_en_i && (addr_i == REG_FLAG);
        rd_low    = rd_en_i && (addr_i == REG_LOW);

        src_pulse = s_q.ctrl.ext_src ? ext_pulse : tick;
        live      = src_pulse && s_q.ctrl.run && (s_q.hold == '0);

        s_d  = s_q;
        wrap = 1'b0;

        if (tick && (s_q.hold != '0)) s_d.hold = s_q.hold - 1'b1;

        if (adv) begin
            if (s_q.ctrl.narrow) begin
                s_d.lo = s_q.lo + 1'b1;
                wrap   = &s_q.lo;
            end else begin
                {s_d.hi, s_d.lo} = {s_q.hi, s_q.lo} + 1'b1;
                wrap             = &{s_q.hi, s_q.lo};
            end
        end

        if (wr_ctrl) s_d.ctrl = ctrl_t'(wdata_i);
        if (rd_low && !s_q.ctrl.narrow) s_d.hbuf = s_q.hi;
        if (wr_hbuf) s_d.hbuf = wdata_i;

        if (wr_low) begin
            s_d.lo   = wdata_i;
            s_d.hold = HW'(HOLD_CYC);
            if (!s_q.ctrl.narrow) s_d.hi = s_q.hbuf;
            wrap     = 1'b0;
        end

        if (wr_flag && !wdata_i[0]) s_d.ovf = 1'b0;
        if (wrap)                   s_d.ovf = 1'b1;

        unique case (addr_i)
            REG_CTRL: rdata_o = s_q.ctrl;
            REG_LOW:  rdata_o = s_q.lo;
            REG_HBUF: rdata_o = s_q.hbuf;
            default:  rdata_o = {{(DW-1){1'b0}}, s_q.ovf};
        endcase

        ovf_o    = s_q.ovf;
        lo_w     = s_q.lo;
        hi_w     = s_q.hi;
        hbuf_w   = s_q.hbuf;
        run_w    = s_q.ctrl.run;
        narrow_w = s_q.ctrl.narrow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.ctrl <= CTRL_RST;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/btc_timer_chk.sv
module btc_timer_chk
    import btc_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    addr,
    input logic          wr_en,
    input logic          rd_en,
    input logic [DW-1:0] wdata,
    input logic          ovf,
    input logic [DW-1:0] lo,
    input logic [DW-1:0] hi,
    input logic [DW-1:0] hbuf,
    input logic          run,
    input logic          narrow
);
    logic wr_low_c;
    assign wr_low_c = wr_en && (addr == REG_LOW);

    AST_LOW_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_low_c |=> (lo == $past(wdata)));                                    // R9
    AST_HIGH_FROM_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_low_c && !narrow) |=> (hi == $past(hbuf)));                        // R9
    AST_STEP_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_low_c |=> ((lo == $past(lo)) || (lo == DW'($past(lo) + 1'b1))));   // R2
    AST_FROZEN_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_low_c) |=> ($stable(lo) && $stable(hi)));                 // R7
    AST_BUF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!(rd_en && addr == REG_LOW) && !(wr_en && addr == REG_HBUF)) |=> $stable(hbuf)); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(wr_en && addr == REG_FLAG && !wdata[0])) |=> ovf);           // R10
endmodule

bind btc_timer btc_timer_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (addr_i),
    .wr_en  (wr_en_i),
    .rd_en  (rd_en_i),
    .wdata  (wdata_i),
    .ovf    (ovf_o),
    .lo     (lo_w),
    .hi     (hi_w),
    .hbuf   (hbuf_w),
    .run    (run_w),
    .narrow (narrow_w)
);

// File: tb/btc_timer_tb.sv
module btc_timer_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       pin = 1'b0;
    logic       ovf;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    btc_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (addr),
        .wr_en_i   (wr_en),
        .rd_en_i   (rd_en),
        .wdata_i   (wdata),
        .rdata_o   (rdata),
        .tmr_pin_i (pin),
        .ovf_o     (ovf)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic rd16(output logic [15:0] v);
        addr = 2'd1; rd_en = 1'b1;
        #1 v[7:0] = rdata;
        @(negedge clk);
        rd_en = 1'b0; addr = 2'd2;
        #1 v[15:8] = rdata;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] cfg(input bit run, input bit narrow, input bit ext,
                                       input bit fall, input bit nopre, input logic [2:0] k);
        return {run, narrow, ext, fall, nopre, k};
    endfunction

    task automatic t_reset();
        logic [7:0] v;
        peek(2'd0, v); chk("R1 ctrl", {8'h0, v}, 16'h00E7);
        peek(2'd1, v); chk("R1 low",  {8'h0, v}, 16'h0000);
        peek(2'd3, v); chk("R1 flag", {8'h0, v}, 16'h0000);
    endtask

    task automatic t_internal_and_hold();
        logic [7:0] a, b;
        wr(2'd0, cfg(1, 1, 0, 0, 1, 3'd0));
        wr(2'd1, 8'h10);
        wait_clk(8);
        peek(2'd1, a); chk("R3 held for two cycles", {8'h0, a}, 16'h0010);
        wait_clk(4);
        peek(2'd1, a); chk("R3 third cycle counts", {8'h0, a}, 16'h0011);
        peek(2'd1, a);
        wait_clk(40);
        peek(2'd1, b); chk("R2 one per instruction cycle", {8'h0, b}, {8'h0, a + 8'd10});
    endtask

    task automatic t_prescale();
        logic [7:0] v;
        wr(2'd0, cfg(1, 1, 0, 0, 0, 3'd0));
        wr(2'd1, 8'h00);
        wait_clk(4 * 34);
        peek(2'd1, v); chk("R4 ratio 1:2", {8'h0, v}, 16'd16);
        wr(2'd0, cfg(1, 1, 0, 0, 0, 3'd2));
        wr(2'd1, 8'h00);
        wait_clk(4 * 42);
        peek(2'd1, v); chk("R4 ratio 1:8", {8'h0, v}, 16'd5);
    endtask

    task automatic t_stop_and_write16();
        logic [7:0]  v;
        logic [15:0] w;
        wr(2'd0, cfg(0, 1, 0, 0, 1, 3'd0));
        wr(2'd1, 8'h33);
        wait_clk(60);
        peek(2'd1, v); chk("R7 stopped count holds", {8'h0, v}, 16'h0033);
        wr(2'd0, cfg(0, 0, 0, 0, 1, 3'd0));
        wr(2'd2, 8'h55);
        wr(2'd1, 8'h10);
        rd16(w); chk("R9 atomic 16-bit write", w, 16'h5510);
        wr(2'd2, 8'hAA);
        rd16(w); chk("R9 buffer write leaves high byte", w, 16'h5510);
    endtask

    task automatic t_atomic_read();
        logic [7:0]  v;
        logic [15:0] w;
        wr(2'd3, 8'h00);
        wr(2'd0, cfg(1, 0, 0, 0, 1, 3'd0));
        wr(2'd2, 8'h12);
        wr(2'd1, 8'hFF);
        wait_clk(7);
        rd16(w); chk("R8 snapshot", w, 16'h12FF);
        wait_clk(12);
        peek(2'd2, v); chk("R8 buffer keeps snapshot", {8'h0, v}, 16'h0012);
        rd16(w); chk("R8 fresh read sees carry", {8'h0, w[15:8]}, 16'h0013);
        peek(2'd3, v); chk("R10 no flag on low-byte carry in 16-bit", {8'h0, v}, 16'h0000);
    endtask

    task automatic t_overflow();
        logic [7:0]  v;
        logic [15:0] w;
        wr(2'd0, cfg(1, 1, 0, 0, 1, 3'd0));
        wr(2'd3, 8'h00);
        wr(2'd1, 8'hFE);
        wait_clk(16);
        peek(2'd1, v); chk("R10 8-bit wrap value", {8'h0, v}, 16'h0000);
        peek(2'd3, v); chk("R10 8-bit wrap flag", {8'h0, v}, 16'h0001);
        wr(2'd3, 8'h01);
        peek(2'd3, v); chk("R10 write 1 no effect", {8'h0, v}, 16'h0001);
        wr(2'd3, 8'h00);
        peek(2'd3, v); chk("R10 write 0 clears", {8'h0, v}, 16'h0000);
        wr(2'd0, cfg(1, 0, 0, 0, 1, 3'd0));
        wr(2'd2, 8'hFF);
        wr(2'd1, 8'hFE);
        wait_clk(16);
        rd16(w); chk("R10 16-bit wrap value", w, 16'h0000);
        peek(2'd3, v); chk("R10 16-bit wrap flag", {8'h0, v}, 16'h0001);
        chk("R10 flag port", {15'h0, ovf}, 16'h0001);
    endtask

    task automatic t_external();
        logic [7:0] v;
        wr(2'd0, cfg(1, 1, 1, 0, 1, 3'd0));
        wait_clk(20);
        wr(2'd1, 8'h00);
        wait_clk(20);
        pin = 1'b1;
        wait_clk(8);
        peek(2'd1, v); chk("R5 synchronizer delay", {8'h0, v}, 16'h0000);
        wait_clk(4);
        peek(2'd1, v); chk("R5 count after delay", {8'h0, v}, 16'h0001);
        pin = 1'b0;
        wait_clk(12);
        for (int i = 0; i < 4; i++) begin
            pin = 1'b1; wait_clk(12);
            pin = 1'b0; wait_clk(12);
        end
        wait_clk(16);
        peek(2'd1, v); chk("R5 rising edges counted", {8'h0, v}, 16'h0005);
        wr(2'd0, cfg(1, 1, 1, 1, 1, 3'd0));
        pin = 1'b1; wait_clk(16);
        peek(2'd1, v); chk("R6 rising edge ignored", {8'h0, v}, 16'h0005);
        pin = 1'b0; wait_clk(16);
        peek(2'd1, v); chk("R6 falling edge counted", {8'h0, v}, 16'h0006);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_internal_and_hold();
        t_prescale();
        t_stop_and_write16();
        t_atomic_read();
        t_overflow();
        t_external();
        done = 1'b1;
        finish_run();
    end
endmodule